// File: doc/BRIEF.md
# Backplane Slot Command Mailbox

This block is the slave side of a processor card's connection to a shared backplane bus. It serves a status read by itself, with no cycle taken from the local processor. The status word shows several pieces of live state: the processor's interrupt-level inputs, whether the processor has halted, whether a command is waiting, a mail byte that the processor can write, and a fixed board identifier.

Any bus access whose low address byte is zero is treated as a command. Its address and data are latched into a single slot. The block then raises a non-maskable interrupt (NMI) to the local processor and sets a pending flag. The block does not record whether the command was a read or a write. While the slot is full, later commands are refused with a nak. The local processor frees the slot by pulsing its ready-count increment. It clears the interrupt separately, by reading the latched command.

Top module: `slot_mailbox`

## Requirements
- R1: A read strobe (`bus_rnw`=1) to word address 0xFFFFFFFC with `bus_byte`=0 sets `stat_valid` for exactly the next cycle, with the status word on `stat_data`. It leaves `cpu_cmd_pend` and `cpu_nmi` unchanged.
- R2: Status word fields:
  - bits 23:21 are `cpu_ipl_n[2:0]` as sampled.
  - bit 20 is the inverse of `cpu_halted`.
  - bit 19 is the pending flag as it stood in the request cycle.
  - bits 18:16 are 3'b111.
  - bits 15:8 are the mail byte.
  - bits 7:0 are 8'h02.
  - bits 31:24 carry no defined value.
- R3: A byte read (`bus_byte`=1) at 0xFFFFFFFC+k returns status byte k on `stat_data[7:0]`, with upper bits zero. Byte lanes are big-endian: k=0 is bits 31:24, k=1 is bits 23:16, k=2 is bits 15:8, k=3 is bits 7:0.
- R4: A strobe whose address low byte is neither 0x00 nor a status decode produces no ack, no nak, no `stat_valid` and no pending change. This includes a write to 0xFFFFFFFC.
- R5: A strobe whose address low byte is 0x00, with the slot empty, sets `cmd_ack` for the next cycle. It also latches the address into `cpu_cmd_addr` and the data into `cpu_cmd_data`, and sets `cpu_cmd_pend` and `cpu_nmi`. The upper address bits are ignored for this decode.
- R6: Read and write commands are captured identically. No output reveals which kind arrived.
- R7: While `cpu_cmd_pend` is 1, a command is refused: `cmd_nak` is set the next cycle and the latched address and data stay unchanged.
- R8: A `cpu_ready_inc` pulse clears `cpu_cmd_pend` at the next edge and leaves `cpu_nmi` unchanged.
- R9: If `cpu_ready_inc` and a command arrive in the same cycle, the command is accepted and captured, and `cpu_cmd_pend` and `cpu_nmi` are 1 afterwards.
- R10: A `cpu_cmd_rd` pulse clears `cpu_nmi` at the next edge and leaves `cpu_cmd_pend` unchanged. If a command is accepted in the same cycle, `cpu_nmi` stays 1.
- R11: `cpu_mail_we` loads `cpu_mail_din` into the mail byte at the clock edge. A status read in a later cycle shows the new value.
- R12: While `rst_n` is low at a clock edge, all outputs and latched state are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_strobe | input | 1 | One-cycle bus access strobe |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = 32-bit access |
| bus_addr | input | 32 | Bus address |
| bus_wdata | input | 32 | Bus data for commands |
| stat_valid | output | 1 | Status response valid |
| stat_data | output | 32 | Status response data |
| cmd_ack | output | 1 | Command accepted (one cycle) |
| cmd_nak | output | 1 | Command refused (one cycle) |
| cpu_ipl_n | input | 3 | Active-low interrupt level at the processor |
| cpu_halted | input | 1 | Processor stopped on double bus error |
| cpu_mail_we | input | 1 | Mail byte write strobe |
| cpu_mail_din | input | 8 | Mail byte value |
| cpu_ready_inc | input | 1 | Ready-count increment pulse, frees the slot |
| cpu_cmd_rd | input | 1 | Processor reads the latched command, clears NMI |
| cpu_nmi | output | 1 | Non-maskable interrupt to the processor |
| cpu_cmd_pend | output | 1 | Command slot full |
| cpu_cmd_addr | output | 32 | Latched command address |
| cpu_cmd_data | output | 32 | Latched command data |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a ready-count increment landing in the very cycle a new command arrives. The other is an NMI acknowledge coinciding with an acceptance. Both require the slot to be filled beforehand, so the directed tasks first fill it with one command, then drive both strobes in a single cycle. The bench then checks that pend and NMI are set and that the new address replaced the old. A separate task splits the two handshakes apart: it clears pend while NMI remains high, and clears NMI while pend remains high, to show that each one is independent of the other.

// File: rtl/slot_mb_pkg.sv
// Package: shared decode kinds and fixed status-word layout for the slot mailbox.
package slot_mb_pkg;
    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_STATUS = 2'd1,
        DEC_CMD    = 2'd2
    } dec_kind_e;

    localparam int STAT_IPL_HI  = 23;
    localparam int STAT_HALT    = 20;
    localparam int STAT_PEND    = 19;
    localparam int STAT_ONES_LO = 16;
    localparam int STAT_MAIL_LO = 8;
endpackage

// File: rtl/slot_mb_decode.sv
// Module: slot_mb_decode
// Classifies a bus strobe as status read, command, or nothing.
// Assumes: status sits in the top word of the address space; commands are
// any address with a zero low byte. The two decodes cannot overlap.
module slot_mb_decode
    import slot_mb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              strobe,
    input  logic              rnw,
    input  logic              byte_acc,
    input  logic [ADDR_W-1:0] addr,
    output dec_kind_e         kind,
    output logic [LANE_W-1:0] lane
);
    localparam int HI_W = ADDR_W - LANE_W;

    logic top_word;
    logic low_zero;

    // Purpose: split the address into the status word match and the command match.
    always_comb begin
        top_word = &addr[ADDR_W-1:LANE_W];
        low_zero = (addr[7:0] == 8'h00);
        lane     = addr[LANE_W-1:0];
        kind     = DEC_NONE;
        if (strobe) begin
            if (top_word && rnw && (byte_acc || lane == '0))
                kind = DEC_STATUS;
            else if (low_zero)
                kind = DEC_CMD;
        end
    end

    // Immediate check: the two decodes never claim the same access. // R4
    always_comb begin
        if (strobe)
            AST_DECODE_DISJOINT: assert (!(top_word && low_zero)); // R4
    end

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/slot_mb_status.sv
// Module: slot_mb_status
// Holds the mail byte, assembles the status word and registers the response
// for a status read, either a whole word or one big-endian byte lane.
// Assumes: DATA_W is a multiple of 8; the status fields sit in the low 24 bits.
module slot_mb_status
    import slot_mb_pkg::*;
#(
    parameter int       DATA_W   = 32,
    parameter int       MAIL_W   = 8,
    parameter logic [7:0] BOARD_ID = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              byte_acc,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic [2:0]        ipl_n,
    input  logic              halted,
    input  logic              pend,
    input  logic              mail_we,
    input  logic [MAIL_W-1:0] mail_din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [MAIL_W-1:0] mail_q;
    logic [DATA_W-1:0] word;
    logic [7:0]        lane_byte;

    // Purpose: processor-side mail byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mail_q <= '0;
        else if (mail_we) mail_q <= mail_din;
    end

    // Purpose: assemble the live status word; the top byte is driven zero.
    always_comb begin
        word = '0;
        word[STAT_IPL_HI -: 3]           = ipl_n;
        word[STAT_HALT]                  = ~halted;
        word[STAT_PEND]                  = pend;
        word[STAT_ONES_LO +: 3]          = 3'b111;
        word[STAT_MAIL_LO +: MAIL_W]     = mail_q;
        word[7:0]                        = BOARD_ID;
    end

    // Purpose: pick one byte lane, lane 0 being the most significant byte.
    always_comb begin
        lane_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i))
                lane_byte = word[DATA_W-1-8*i -: 8];
        end
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= hit;
            if (hit)
                data <= byte_acc ? {{(DATA_W-8){1'b0}}, lane_byte} : word;
        end
    end

    AST_STAT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> valid); // R1
    AST_STAT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !valid); // R4
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && byte_acc) |=> (data[DATA_W-1:8] == '0)); // R3
    AST_MAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mail_we |=> (mail_q == $past(mail_din))); // R11
endmodule

// File: rtl/slot_mb_cmd.sv
// Module: slot_mb_cmd
// One-entry command slot: latches address and data, raises pend and NMI,
// refuses commands while full. A ready pulse frees the slot (the clear is
// taken before a same-cycle command); a command read drops NMI.
// Assumes: ready and command-read are single-cycle pulses from the processor.
module slot_mb_cmd #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready_inc,
    input  logic              cmd_rd,
    output logic              pend,
    output logic              nmi,
    output logic              ack,
    output logic              nak,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    logic accept;

    // Purpose: a command is taken when the slot is empty or being freed now.
    always_comb accept = hit && (!pend || ready_inc);

    // Purpose: capture the command and track the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            if (accept) begin
                pend     <= 1'b1;
                cmd_addr <= addr;
                cmd_data <= wdata;
            end else if (ready_inc) begin
                pend     <= 1'b0;
            end
        end
    end

    // Purpose: NMI set by acceptance, cleared by the processor's command read.
    always_ff @(posedge clk) begin
        if (!rst_n)      nmi <= 1'b0;
        else if (accept) nmi <= 1'b1;
        else if (cmd_rd) nmi <= 1'b0;
    end

    // Purpose: one-cycle ack or nak back to the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            nak <= 1'b0;
        end else begin
            ack <= accept;
            nak <= hit && !accept;
        end
    end

    AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (pend && nmi)); // R5
    AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && nak)); // R7
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pend && !ready_inc) |=> (nak && $stable(cmd_addr) && $stable(cmd_data))); // R7
    AST_READY_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_inc && !hit) |=> (!pend && nmi == $past(nmi))); // R8
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_inc && hit) |=> (ack && pend && nmi)); // R9
    AST_NMI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !hit && !ready_inc) |=> (!nmi && pend == $past(pend))); // R10
endmodule

// File: rtl/slot_mailbox.sv
// Module: slot_mailbox (top)
// Backplane slave for a processor card: serves the status read without the
// processor, and captures commands into a one-entry slot that raises NMI.
// Assumes: one bus strobe per cycle at most; 32-bit address and data.
module slot_mailbox
    import slot_mb_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         DATA_W   = 32,
    parameter int         MAIL_W   = 8,
    parameter logic [7:0] BOARD_ID = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strobe,
    input  logic              bus_rnw,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data,
    output logic              cmd_ack,
    output logic              cmd_nak,
    input  logic [2:0]        cpu_ipl_n,
    input  logic              cpu_halted,
    input  logic              cpu_mail_we,
    input  logic [MAIL_W-1:0] cpu_mail_din,
    input  logic              cpu_ready_inc,
    input  logic              cpu_cmd_rd,
    output logic              cpu_nmi,
    output logic              cpu_cmd_pend,
    output logic [ADDR_W-1:0] cpu_cmd_addr,
    output logic [DATA_W-1:0] cpu_cmd_data
);
    localparam int LANE_W = $clog2(DATA_W / 8);

    dec_kind_e         kind;
    logic [LANE_W-1:0] lane;
    logic              stat_hit;
    logic              cmd_hit;

    slot_mb_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_decode (
        .strobe   (bus_strobe),
        .rnw      (bus_rnw),
        .byte_acc (bus_byte),
        .addr     (bus_addr),
        .kind     (kind),
        .lane     (lane)
    );

    // Purpose: fan the decode result out to the two halves.
    always_comb begin
        stat_hit = (kind == DEC_STATUS);
        cmd_hit  = (kind == DEC_CMD);
    end

    slot_mb_status #(.DATA_W(DATA_W), .MAIL_W(MAIL_W), .BOARD_ID(BOARD_ID)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (stat_hit),
        .byte_acc (bus_byte),
        .lane     (lane),
        .ipl_n    (cpu_ipl_n),
        .halted   (cpu_halted),
        .pend     (cpu_cmd_pend),
        .mail_we  (cpu_mail_we),
        .mail_din (cpu_mail_din),
        .valid    (stat_valid),
        .data     (stat_data)
    );

    slot_mb_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (cmd_hit),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ready_inc (cpu_ready_inc),
        .cmd_rd    (cpu_cmd_rd),
        .pend      (cpu_cmd_pend),
        .nmi       (cpu_nmi),
        .ack       (cmd_ack),
        .nak       (cmd_nak),
        .cmd_addr  (cpu_cmd_addr),
        .cmd_data  (cpu_cmd_data)
    );

    AST_STATUS_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && !cpu_ready_inc && !cpu_cmd_rd) |=>
            ($stable(cpu_cmd_pend) && $stable(cpu_nmi) && !cmd_ack && !cmd_nak)); // R1
endmodule

// File: tb/slot_mailbox_test.sv
// Directed bench for slot_mailbox: one task per scenario, each self-checking.
module slot_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_strobe = 1'b0, bus_rnw = 1'b0, bus_byte = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        stat_valid, cmd_ack, cmd_nak, cpu_nmi, cpu_cmd_pend;
    logic [31:0] stat_data, cpu_cmd_addr, cpu_cmd_data;
    logic [2:0]  cpu_ipl_n = 3'b111;
    logic        cpu_halted = 1'b0, cpu_mail_we = 1'b0;
    logic [7:0]  cpu_mail_din = '0;
    logic        cpu_ready_inc = 1'b0, cpu_cmd_rd = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    slot_mailbox uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, sample just after the edge, then return to idle.
    task automatic step(input logic strobe, input logic rnw, input logic bytea,
                        input logic [31:0] addr, input logic [31:0] wd,
                        input logic rdy, input logic crd);
        @(negedge clk);
        bus_strobe = strobe; bus_rnw = rnw; bus_byte = bytea;
        bus_addr = addr; bus_wdata = wd;
        cpu_ready_inc = rdy; cpu_cmd_rd = crd;
        @(posedge clk); #1;
        bus_strobe = 0; cpu_ready_inc = 0; cpu_cmd_rd = 0; cpu_mail_we = 0;
    endtask

    task automatic t_reset;
        chk("R12 valid", {31'b0, stat_valid}, 0);
        chk("R12 ack/nak", {30'b0, cmd_ack, cmd_nak}, 0);
        chk("R12 pend/nmi", {30'b0, cpu_cmd_pend, cpu_nmi}, 0);
        chk("R12 addr", cpu_cmd_addr, 0);
        chk("R12 data", cpu_cmd_data, 0);
    endtask

    task automatic t_status;
        cpu_ipl_n = 3'b101; cpu_halted = 0;
        step(1, 1, 0, 32'hFFFF_FFFC, 0, 0, 0);
        chk("R1 valid", {31'b0, stat_valid}, 1);
        chk("R2 word", {8'h00, stat_data[23:0]}, 32'h00B7_0002);
        chk("R1 no pend", {30'b0, cpu_cmd_pend, cpu_nmi}, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R1 one cycle", {31'b0, stat_valid}, 0);
    endtask

    task automatic t_mail_bytes;
        @(negedge clk); cpu_mail_we = 1; cpu_mail_din = 8'h5A;
        cpu_halted = 1; cpu_ipl_n = 3'b000;
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 32'hFFFF_FFFC, 0, 0, 0);
        chk("R11 mail in word", {8'h00, stat_data[23:0]}, 32'h0007_5A02);
        step(1, 1, 1, 32'hFFFF_FFFD, 0, 0, 0);
        chk("R3 lane1", stat_data, 32'h07);
        step(1, 1, 1, 32'hFFFF_FFFE, 0, 0, 0);
        chk("R3 lane2", stat_data, 32'h5A);
        step(1, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R3 lane3", stat_data, 32'h02);
    endtask

    task automatic t_ignore;
        step(1, 0, 0, 32'h1234_5610, 32'hDEAD_BEEF, 0, 0);
        chk("R4 odd addr", {28'b0, stat_valid, cmd_ack, cmd_nak, cpu_cmd_pend}, 0);
        step(1, 0, 0, 32'hFFFF_FFFC, 32'hDEAD_BEEF, 0, 0);
        chk("R4 status write", {28'b0, stat_valid, cmd_ack, cmd_nak, cpu_cmd_pend}, 0);
        chk("R4 addr untouched", cpu_cmd_addr, 0);
    endtask

    task automatic t_command;
        step(1, 0, 0, 32'hABCD_EF00, 32'h1122_3344, 0, 0);
        chk("R5 ack", {30'b0, cmd_ack, cmd_nak}, 2);
        chk("R5 pend/nmi", {30'b0, cpu_cmd_pend, cpu_nmi}, 3);
        chk("R5 addr", cpu_cmd_addr, 32'hABCD_EF00);
        chk("R5 data", cpu_cmd_data, 32'h1122_3344);
        step(1, 1, 0, 32'hFFFF_FFFC, 0, 0, 0);
        chk("R2 pend bit", {31'b0, stat_data[19]}, 1);
    endtask

    task automatic t_refuse;
        step(1, 0, 0, 32'h9999_9900, 32'h7777_7777, 0, 0);
        chk("R7 nak", {30'b0, cmd_ack, cmd_nak}, 1);
        chk("R7 addr held", cpu_cmd_addr, 32'hABCD_EF00);
        chk("R7 data held", cpu_cmd_data, 32'h1122_3344);
    endtask

    task automatic t_handshakes;
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R8 pend cleared nmi kept", {30'b0, cpu_cmd_pend, cpu_nmi}, 1);
        step(1, 1, 0, 32'h55AA_0000, 32'hCAFE_F00D, 0, 0);
        chk("R6 read cmd ack", {30'b0, cmd_ack, cmd_nak}, 2);
        chk("R6 read cmd addr", cpu_cmd_addr, 32'h55AA_0000);
        chk("R6 read cmd pend/nmi", {30'b0, cpu_cmd_pend, cpu_nmi}, 3);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R10 nmi cleared pend kept", {30'b0, cpu_cmd_pend, cpu_nmi}, 2);
    endtask

    task automatic t_collide;
        step(1, 0, 0, 32'h0102_0300, 32'hA5A5_A5A5, 1, 0);
        chk("R9 ack", {30'b0, cmd_ack, cmd_nak}, 2);
        chk("R9 pend/nmi", {30'b0, cpu_cmd_pend, cpu_nmi}, 3);
        chk("R9 addr", cpu_cmd_addr, 32'h0102_0300);
        step(1, 0, 0, 32'h0A0B_0C00, 32'h5A5A_5A5A, 1, 1);
        chk("R10 accept beats clear", {30'b0, cpu_cmd_pend, cpu_nmi}, 3);
        chk("R9 second addr", cpu_cmd_addr, 32'h0A0B_0C00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; t_reset;
        @(negedge clk); rst_n = 1;
        t_status;
        t_mail_bytes;
        t_ignore;
        t_command;
        t_refuse;
        t_handshakes;
        t_collide;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule